// File: doc/BRIEF.md
# Modulus Up/Down Counter with Priority Controls

A parameterized binary counter whose cycle length is set by a modulus parameter and whose direction comes from an input or from a fixed parameter. Three ways of forcing the count exist: clear to zero, set to all ones or a configured preset, and load from a parallel data bus. Each comes in an asynchronous form, which acts at once without a clock edge, and a synchronous form, which acts on the rising clock edge. The two groups each follow their own fixed priority.

A clock enable gates every synchronous action. A separate count enable gates only counting. A 16-bit decode output marks which of the counts 0 to 15 the counter currently holds. A typical use is a divider, a timer or an address sequencer that has to be preset or reloaded in the middle of a run.

Top module: `mod_updown_counter`

## Requirements
- R1: The asynchronous controls change `count` without a clock edge, with priority clear (to 0) over set over load (from `dataIn`). While one of them is held high, a clock edge leaves the forced value in place.
- R2: Asynchronous set gives `ASET_VALUE`, and synchronous set gives `SSET_VALUE`. A negative value for either parameter means all ones.
- R3: With `clkEn` low and no asynchronous control active, `count` holds, and synchronous clear, set and load have no effect.
- R4: With `clkEn` high, a rising clock edge applies synchronous clear, otherwise set, otherwise load, otherwise counting. The first of these that is requested wins.
- R5: With `cntEn` low, `count` does not step, but synchronous clear, set and load still act.
- R6: `DIRECTION` 0 takes the direction from `upDn`, where 1 means up and 0 means down. `DIRECTION` 1 always counts up and `DIRECTION` 2 always counts down, whatever `upDn` is.
- R7: The counter cycles through `MODULUS` states: counting up from `MODULUS`-1 gives 0, and counting down from 0 gives `MODULUS`-1. `MODULUS` 0 selects 2^`WIDTH` states. Loaded values must be below the modulus.
- R8: `countIs[k]` is high exactly when `count` equals k, for k from 0 to 15. It follows `count` without a register stage, and it is all zero for counts of 16 and above.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| clkEn | input | 1 | Enables all synchronous actions |
| cntEn | input | 1 | Enables counting only |
| upDn | input | 1 | Direction: 1 up, 0 down (used when DIRECTION is 0) |
| dataIn | input | WIDTH | Parallel value for both loads |
| asyncClr | input | 1 | Asynchronous clear, highest priority |
| asyncSet | input | 1 | Asynchronous set to ASET_VALUE |
| asyncLoad | input | 1 | Asynchronous load from dataIn |
| syncClr | input | 1 | Synchronous clear |
| syncSet | input | 1 | Synchronous set to SSET_VALUE |
| syncLoad | input | 1 | Synchronous load from dataIn |
| count | output | WIDTH | Current count |
| countIs | output | 16 | One-hot decode of counts 0 to 15 |

## Verification
The case that is hardest to reach from the ports is the wrap edge in a short modulus. With a full binary range, wrapping looks the same as plain rollover, so a broken wrap compare would go unnoticed there. The bench therefore drives a second instance with a modulus of 12 and a fixed down direction, using the same vector stream, with its load data reduced modulo 12. The vectors load values close to both ends of the range and then step through the wrap. They also combine clear, set and load requests under a low clock enable or a low count enable, so that every step of the priority chain is observed.

// File: rtl/modctr_pkg.sv
package modctr_pkg;
  typedef struct packed {
    logic doClear;
    logic doSet;
    logic doLoad;
    logic doCount;
    logic dirUp;
  } ctrStrobes_t;
endpackage

// File: rtl/ctr_ctrl.sv
module ctr_ctrl
  import modctr_pkg::*;
#(
  parameter int DIRECTION = 0
) (
  input  logic        clkEn,
  input  logic        cntEn,
  input  logic        upDn,
  input  logic        syncClr,
  input  logic        syncSet,
  input  logic        syncLoad,
  output ctrStrobes_t strobes
);
  always_comb begin
    strobes = '0;
    strobes.dirUp = (DIRECTION == 0) ? upDn : (DIRECTION == 1);
    if (clkEn) begin
      if (syncClr)       strobes.doClear = 1'b1;
      else if (syncSet)  strobes.doSet   = 1'b1;
      else if (syncLoad) strobes.doLoad  = 1'b1;
      else if (cntEn)    strobes.doCount = 1'b1;
    end
  end
endmodule

// File: rtl/ctr_datapath.sv
module ctr_datapath
  import modctr_pkg::*;
#(
  parameter int WIDTH      = 8,
  parameter int MODULUS    = 0,
  parameter int ASET_VALUE = -1,
  parameter int SSET_VALUE = 37
) (
  input  logic             clk,
  input  logic             asyncClr,
  input  logic             asyncSet,
  input  logic             asyncLoad,
  input  logic [WIDTH-1:0] dataIn,
  input  ctrStrobes_t      strobes,
  output logic [WIDTH-1:0] cntQ
);
  localparam longint MOD_EFF = (MODULUS == 0) ? (longint'(1) << WIDTH) : longint'(MODULUS);
  localparam logic [WIDTH-1:0] MAX_CNT = WIDTH'(MOD_EFF - 1);
  localparam logic [WIDTH-1:0] A_PRESET = (ASET_VALUE < 0) ? {WIDTH{1'b1}} : WIDTH'(ASET_VALUE);
  localparam logic [WIDTH-1:0] S_PRESET = (SSET_VALUE < 0) ? {WIDTH{1'b1}} : WIDTH'(SSET_VALUE);

  logic [WIDTH-1:0] stepVal;
  logic [WIDTH-1:0] nextVal;

  always_comb begin
    if (strobes.dirUp) stepVal = (cntQ == MAX_CNT) ? '0 : cntQ + 1'b1;
    else               stepVal = (cntQ == '0) ? MAX_CNT : cntQ - 1'b1;
  end

  always_comb begin
    nextVal = cntQ;
    if (strobes.doClear)      nextVal = '0;
    else if (strobes.doSet)   nextVal = S_PRESET;
    else if (strobes.doLoad)  nextVal = dataIn;
    else if (strobes.doCount) nextVal = stepVal;
  end

  always_ff @(posedge clk or posedge asyncClr or posedge asyncSet or posedge asyncLoad) begin
    if (asyncClr)       cntQ <= '0;
    else if (asyncSet)  cntQ <= A_PRESET;
    else if (asyncLoad) cntQ <= dataIn;
    else                cntQ <= nextVal;
  end

  // R4
  sync_clear_chk: assert property (@(posedge clk) disable iff (asyncClr || asyncSet || asyncLoad)
    strobes.doClear |=> cntQ == '0);

  // R7
  in_range_chk: assert property (@(posedge clk) disable iff (asyncClr)
    cntQ <= MAX_CNT);
endmodule

// File: rtl/ctr_decode.sv
module ctr_decode #(
  parameter int WIDTH = 8
) (
  input  logic [WIDTH-1:0] count,
  input  logic             clk,
  input  logic             asyncClr,
  output logic [15:0]      countIs
);
  localparam int PAD = 32 - WIDTH;

  logic [31:0] wideCnt;
  assign wideCnt = {{PAD{1'b0}}, count};

  for (genvar k = 0; k < 16; k++) begin : g_dec
    assign countIs[k] = (wideCnt == 32'(k));
  end

  // R8
  onehot_dec_chk: assert property (@(posedge clk) disable iff (asyncClr)
    $onehot0(countIs) && ((wideCnt < 32'd16) == (countIs != 16'h0)));
endmodule

// File: rtl/mod_updown_counter.sv
module mod_updown_counter
  import modctr_pkg::*;
#(
  parameter int WIDTH      = 8,
  parameter int MODULUS    = 0,
  parameter int DIRECTION  = 0,
  parameter int ASET_VALUE = -1,
  parameter int SSET_VALUE = 37
) (
  input  logic             clk,
  input  logic             clkEn,
  input  logic             cntEn,
  input  logic             upDn,
  input  logic [WIDTH-1:0] dataIn,
  input  logic             asyncClr,
  input  logic             asyncSet,
  input  logic             asyncLoad,
  input  logic             syncClr,
  input  logic             syncSet,
  input  logic             syncLoad,
  output logic [WIDTH-1:0] count,
  output logic [15:0]      countIs
);
  ctrStrobes_t strobes;
  logic        asyncAny;

  assign asyncAny = asyncClr | asyncSet | asyncLoad;

  ctr_ctrl #(.DIRECTION(DIRECTION)) u_ctrl (
    .clkEn(clkEn), .cntEn(cntEn), .upDn(upDn),
    .syncClr(syncClr), .syncSet(syncSet), .syncLoad(syncLoad),
    .strobes(strobes)
  );

  ctr_datapath #(
    .WIDTH(WIDTH), .MODULUS(MODULUS),
    .ASET_VALUE(ASET_VALUE), .SSET_VALUE(SSET_VALUE)
  ) u_dp (
    .clk(clk), .asyncClr(asyncClr), .asyncSet(asyncSet), .asyncLoad(asyncLoad),
    .dataIn(dataIn), .strobes(strobes), .cntQ(count)
  );

  ctr_decode #(.WIDTH(WIDTH)) u_dec (
    .count(count), .clk(clk), .asyncClr(asyncClr), .countIs(countIs)
  );

  // R3
  hold_when_disabled_chk: assert property (@(posedge clk) disable iff (asyncAny)
    !clkEn |=> $stable(count));

  // R5
  no_step_without_cnten_chk: assert property (@(posedge clk) disable iff (asyncAny)
    (clkEn && !cntEn && !syncClr && !syncSet && !syncLoad) |=> $stable(count));
endmodule

// File: tb/tb_mod_updown_counter.sv
module tb_mod_updown_counter;
  localparam int MODB = 12;
  localparam int NV = 24;
  // fields: clkEn cntEn upDn syncClr syncSet syncLoad data[7:0]
  localparam logic [13:0] VEC [NV] = '{
    {6'b111000, 8'd0},   {6'b111000, 8'd0},   {6'b110000, 8'd0},
    {6'b110000, 8'd0},   {6'b110000, 8'd0},   {6'b110000, 8'd0},
    {6'b111001, 8'd253}, {6'b111000, 8'd0},   {6'b111000, 8'd0},
    {6'b111000, 8'd0},   {6'b011100, 8'd0},   {6'b010010, 8'd0},
    {6'b010001, 8'd44},  {6'b101001, 8'd14},  {6'b101000, 8'd0},
    {6'b111000, 8'd0},   {6'b111000, 8'd0},   {6'b111110, 8'd0},
    {6'b111011, 8'd99},  {6'b110111, 8'd77},  {6'b110000, 8'd0},
    {6'b100000, 8'd0},   {6'b111001, 8'd11},  {6'b111000, 8'd0}
  };

  logic       clk = 1'b0;
  logic       clkEn, cntEn, upDn, asyncClr, asyncSet, asyncLoad, syncClr, syncSet, syncLoad;
  logic [7:0] dataA, dataB, countA, countB;
  logic [15:0] isA, isB;
  int checks = 0;
  int errors = 0;
  logic [7:0] expA, expB;

  always #5 clk = ~clk;

  mod_updown_counter #(.WIDTH(8), .MODULUS(0), .DIRECTION(0), .ASET_VALUE(-1), .SSET_VALUE(37)) dut (
    .clk(clk), .clkEn(clkEn), .cntEn(cntEn), .upDn(upDn), .dataIn(dataA),
    .asyncClr(asyncClr), .asyncSet(asyncSet), .asyncLoad(asyncLoad),
    .syncClr(syncClr), .syncSet(syncSet), .syncLoad(syncLoad),
    .count(countA), .countIs(isA));

  mod_updown_counter #(.WIDTH(8), .MODULUS(MODB), .DIRECTION(2), .ASET_VALUE(5), .SSET_VALUE(9)) dutMod (
    .clk(clk), .clkEn(clkEn), .cntEn(cntEn), .upDn(upDn), .dataIn(dataB),
    .asyncClr(asyncClr), .asyncSet(asyncSet), .asyncLoad(asyncLoad),
    .syncClr(syncClr), .syncSet(syncSet), .syncLoad(syncLoad),
    .count(countB), .countIs(isB));

  function automatic logic [7:0] refNext(logic [7:0] cur, logic [13:0] v, int modv,
                                         logic [7:0] sval, int dirMode, logic [7:0] d);
    logic up;
    if (!v[13]) return cur;
    if (v[10]) return 8'd0;
    if (v[9])  return sval;
    if (v[8])  return d;
    if (!v[12]) return cur;
    up = (dirMode == 0) ? v[11] : (dirMode == 1);
    if (up) return (int'(cur) == modv - 1) ? 8'd0 : cur + 8'd1;
    return (cur == 8'd0) ? 8'(modv - 1) : cur - 8'd1;
  endfunction

  function automatic logic [15:0] refDec(logic [7:0] c);
    return (c < 8'd16) ? (16'd1 << c) : 16'd0;
  endfunction

  task automatic chk(string tag, logic [15:0] act, logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic checkBoth(string tag);
    chk(tag, {8'd0, countA}, {8'd0, expA});
    chk(tag, {8'd0, countB}, {8'd0, expB});
    chk("R8", isA, refDec(expA));
    chk("R8", isB, refDec(expB));
  endtask

  task automatic asyncOp(logic c, logic s, logic l, logic [7:0] d,
                         logic [7:0] eA, logic [7:0] eB, string tag);
    @(negedge clk);
    clkEn = 1'b1; cntEn = 1'b1;
    dataA = d; dataB = 8'(d % MODB);
    asyncClr = c; asyncSet = s; asyncLoad = l;
    expA = eA; expB = eB;
    #1 checkBoth(tag);
    @(posedge clk); #2 checkBoth(tag);
    @(negedge clk);
    clkEn = 1'b0;
    asyncClr = 1'b0; asyncSet = 1'b0; asyncLoad = 1'b0;
    #1 checkBoth(tag);
  endtask

  initial begin
    #100000;
    errors++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    asyncClr = 1'b1; asyncSet = 1'b0; asyncLoad = 1'b0;
    clkEn = 1'b0; cntEn = 1'b0; upDn = 1'b1;
    syncClr = 1'b0; syncSet = 1'b0; syncLoad = 1'b0;
    dataA = 8'd0; dataB = 8'd0;
    expA = 8'd0; expB = 8'd0;
    @(negedge clk); @(negedge clk);
    asyncClr = 1'b0;
    #1 checkBoth("R1");   // reset state via clear

    foreach (VEC[i]) begin
      logic [13:0] v;
      string tag;
      v = VEC[i];
      @(negedge clk);
      {clkEn, cntEn, upDn, syncClr, syncSet, syncLoad} = v[13:8];
      dataA = v[7:0];
      dataB = 8'(v[7:0] % MODB);
      if (!v[13]) tag = "R3";
      else if (v[9] && !v[10]) tag = "R2";
      else if (v[10] || v[8]) tag = "R4";
      else if (!v[12]) tag = "R5";
      else if ((v[11] && expA == 8'd255) || expB == 8'd0) tag = "R7";
      else tag = "R6";
      expA = refNext(expA, v, 256, 8'd37, 0, dataA);
      expB = refNext(expB, v, MODB, 8'd9, 2, dataB);
      @(posedge clk); #2 checkBoth(tag);
    end

    // R2: asynchronous set, all ones vs preset 5
    asyncOp(1'b0, 1'b1, 1'b0, 8'd0, 8'd255, 8'd5, "R2");
    // R1: asynchronous load from data
    asyncOp(1'b0, 1'b0, 1'b1, 8'd90, 8'd90, 8'd6, "R1");
    // R1: clear dominates set and load
    asyncOp(1'b1, 1'b1, 1'b1, 8'd7, 8'd0, 8'd0, "R1");
    // R1: set dominates load
    asyncOp(1'b0, 1'b1, 1'b1, 8'd7, 8'd255, 8'd5, "R1");

    // R3: clock enable low suppresses a synchronous clear
    @(negedge clk);
    clkEn = 1'b0; syncClr = 1'b1;
    @(posedge clk); #2 checkBoth("R3");
    @(negedge clk); syncClr = 1'b0;

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule